// File: doc/BRIEF.md
# Dual-Clock Bypass Mailbox Pair

This block carries short control words between two independently clocked ports without going through a data queue. It holds two 36-bit mailboxes. The forward mailbox (mail1) is written from port A and read at port B. The return mailbox (mail2) is written from port B and read at port A. Each port has its own clock and the same set of controls: chip select, transfer direction, enable and mailbox select.

Each mailbox has a status flag that is high while the mailbox is empty and low while mail is unread. The flag appears in both clock domains. A write notification crosses from the writer to the reader, and a read acknowledge crosses back. Each crossing is a toggle passed through a two-flop synchronizer. A mailbox refuses new writes until the reader's acknowledge has come back to the writer, so its data is stable whenever the reader can see it.

Each port's read-data output chooses between the queue's output word, which is supplied from outside, and the opposite mailbox.

Top module: `dual_mailbox`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and afterwards until the first accepted write, all four empty flags read 1 and both mailboxes hold zero.
- R2: On a rising `clk_a` edge with `a_cs`=1, `a_dir`=1 (1 = write, 0 = read), `a_en`=1 and `a_mbsel`=1 while `a_mb1_empty`=1, mail1 captures `a_din` and `a_mb1_empty` goes to 0 after that edge.
- R3: On a rising `clk_b` edge with `b_cs`=1, `b_dir`=1, `b_en`=1 and `b_mbsel`=1 while `b_mb2_empty`=1, mail2 captures `b_din` and `b_mb2_empty` goes to 0 after that edge.
- R4: A mailbox write attempted while the writer-side flag of that mailbox is 0 is ignored, and the stored word is unchanged.
- R5: A port cycle in which any of cs, dir, en or mbsel is 0 does not change either mailbox.
- R6: The reader-side flag (`b_mb1_empty` or `a_mb2_empty`) goes to 0 after the second reader-clock rising edge that follows the accepting write edge.
- R7: A mailbox read (cs=1, dir=0, en=1, mbsel=1) on the reader's rising edge while the reader-side flag is 0 sets that flag to 1 after the edge. The writer-side flag returns to 1 after the second writer-clock rising edge that follows.
- R8: Reading a mailbox leaves its contents unchanged. Only an accepted write changes them.
- R9: A mailbox read while the reader-side flag is 1 returns the stored word and changes no flag.
- R10: `a_dout` shows mail2 when `a_mbsel`=1 and `a_fifo_q` when `a_mbsel`=0. `b_dout` shows mail1 when `b_mbsel`=1 and `b_fifo_q` when `b_mbsel`=0.
- R11: `a_oe` equals `a_cs` AND NOT `a_dir`, and `b_oe` equals `b_cs` AND NOT `b_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| a_cs | input | 1 | Port A chip select |
| a_dir | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A transfer enable |
| a_mbsel | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output word for port A |
| a_dout | output | 36 | Port A read data |
| a_oe | output | 1 | Port A output active |
| a_mb1_empty | output | 1 | mail1 empty flag, clk_a domain |
| a_mb2_empty | output | 1 | mail2 empty flag, clk_a domain |
| b_cs | input | 1 | Port B chip select |
| b_dir | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B transfer enable |
| b_mbsel | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output word for port B |
| b_dout | output | 36 | Port B read data |
| b_oe | output | 1 | Port B output active |
| b_mb1_empty | output | 1 | mail1 empty flag, clk_b domain |
| b_mb2_empty | output | 1 | mail2 empty flag, clk_b domain |

## Verification
The two clocks run at unrelated periods whose rising edges never coincide, so each crossing is tried with several phase relations. A clean single message in each direction shows the two-edge latency on both the notify path and the acknowledge path. A second write while mail is pending, and cycles with one qualifier dropped, show that the guard refuses a write rather than overwriting the stored word. Reads with the flag already high, and reads with mailbox select low, separate retained-data behaviour from output routing.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned MBOX_W_DEF = 36;

  typedef struct packed {
    logic cs;
    logic dir;    // 1 = write, 0 = read
    logic en;
    logic mbsel;
  } port_ctl_t;

  function automatic logic mb_write_hit(port_ctl_t c);
    return c.cs & c.dir & c.en & c.mbsel;
  endfunction

  function automatic logic mb_read_hit(port_ctl_t c);
    return c.cs & ~c.dir & c.en & c.mbsel;
  endfunction

  function automatic logic port_drives(port_ctl_t c);
    return c.cs & ~c.dir;
  endfunction

  // Two toggles that differ mean an event is still in flight.
  function automatic logic tog_differs(logic mine, logic theirs);
    return mine ^ theirs;
  endfunction

endpackage

// File: rtl/mbox_sync2.sv
module mbox_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned W = 36
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         rd_hit,
  output logic [W-1:0] mail_q,
  output logic         wr_empty,
  output logic         rd_empty,
  output logic         wr_accept,
  output logic         rd_ack
);
  import mbox_pkg::*;

  logic wr_tog, ack_tog;
  logic wr_tog_at_rd, ack_tog_at_wr;
  logic wr_pending, rd_pending;

  // writer domain
  assign wr_pending = tog_differs(wr_tog, ack_tog_at_wr);
  assign wr_accept  = wr_hit & ~wr_pending;
  assign wr_empty   = ~wr_pending;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      mail_q <= '0;
      wr_tog <= 1'b0;
    end else if (wr_accept) begin
      mail_q <= wr_data;
      wr_tog <= ~wr_tog;
    end
  end

  mbox_sync2 u_ack_sync (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .d     (ack_tog),
    .q     (ack_tog_at_wr)
  );

  // reader domain
  mbox_sync2 u_ntf_sync (
    .clk   (rd_clk),
    .rst_n (rst_n),
    .d     (wr_tog),
    .q     (wr_tog_at_rd)
  );

  assign rd_pending = tog_differs(wr_tog_at_rd, ack_tog);
  assign rd_ack     = rd_hit & rd_pending;
  assign rd_empty   = ~rd_pending;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)      ack_tog <= 1'b0;
    else if (rd_ack) ack_tog <= ~ack_tog;
  end
endmodule

// File: rtl/mbox_port_mux.sv
module mbox_port_mux #(
  parameter int unsigned W = 36
) (
  input  logic         sel_mail,
  input  logic         drive,
  input  logic [W-1:0] fifo_q,
  input  logic [W-1:0] mail_q,
  output logic [W-1:0] dout,
  output logic         oe
);
  assign dout = sel_mail ? mail_q : fifo_q;
  assign oe   = drive;
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned W = MBOX_W_DEF
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs,
  input  logic         a_dir,
  input  logic         a_en,
  input  logic         a_mbsel,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  output logic         a_mb1_empty,
  output logic         a_mb2_empty,
  input  logic         b_cs,
  input  logic         b_dir,
  input  logic         b_en,
  input  logic         b_mbsel,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  output logic         b_mb1_empty,
  output logic         b_mb2_empty
);
  localparam int unsigned NPORT = 2;

  // index 0 = port A, 1 = port B; channel n is written by port n
  logic         clk_v    [NPORT];
  port_ctl_t    ctl_v    [NPORT];
  logic [W-1:0] din_v    [NPORT];
  logic [W-1:0] fifo_v   [NPORT];
  logic [W-1:0] dout_v   [NPORT];
  logic [W-1:0] mail_v   [NPORT];
  logic [NPORT-1:0] oe_v;
  logic [NPORT-1:0] wr_hit_v, rd_hit_v, accept_v, ack_v;
  logic [NPORT-1:0] wr_empty_v, rd_empty_v;

  assign clk_v[0]  = clk_a;
  assign clk_v[1]  = clk_b;
  assign ctl_v[0]  = '{cs: a_cs, dir: a_dir, en: a_en, mbsel: a_mbsel};
  assign ctl_v[1]  = '{cs: b_cs, dir: b_dir, en: b_en, mbsel: b_mbsel};
  assign din_v[0]  = a_din;
  assign din_v[1]  = b_din;
  assign fifo_v[0] = a_fifo_q;
  assign fifo_v[1] = b_fifo_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned OTHER = NPORT - 1 - p;

    assign wr_hit_v[p] = mb_write_hit(ctl_v[p]);
    assign rd_hit_v[p] = mb_read_hit(ctl_v[p]);

    mbox_channel #(.W(W)) u_chan (
      .wr_clk    (clk_v[p]),
      .rd_clk    (clk_v[OTHER]),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit_v[p]),
      .wr_data   (din_v[p]),
      .rd_hit    (rd_hit_v[OTHER]),
      .mail_q    (mail_v[p]),
      .wr_empty  (wr_empty_v[p]),
      .rd_empty  (rd_empty_v[p]),
      .wr_accept (accept_v[p]),
      .rd_ack    (ack_v[p])
    );

    mbox_port_mux #(.W(W)) u_mux (
      .sel_mail (ctl_v[p].mbsel),
      .drive    (port_drives(ctl_v[p])),
      .fifo_q   (fifo_v[p]),
      .mail_q   (mail_v[OTHER]),
      .dout     (dout_v[p]),
      .oe       (oe_v[p])
    );
  end

  // named internal events for the checker
  logic [W-1:0] mail1_q, mail2_q;
  assign mail1_q = mail_v[0];
  assign mail2_q = mail_v[1];

  assign a_dout      = dout_v[0];
  assign b_dout      = dout_v[1];
  assign a_oe        = oe_v[0];
  assign b_oe        = oe_v[1];
  assign a_mb1_empty = wr_empty_v[0];
  assign b_mb1_empty = rd_empty_v[0];
  assign b_mb2_empty = wr_empty_v[1];
  assign a_mb2_empty = rd_empty_v[1];
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_n,
  input logic [1:0]   wr_hit_v,
  input logic [1:0]   accept_v,
  input logic [1:0]   ack_v,
  input logic [W-1:0] a_din,
  input logic [W-1:0] b_din,
  input logic [W-1:0] mail1_q,
  input logic [W-1:0] mail2_q,
  input logic         a_mb1_empty,
  input logic         a_mb2_empty,
  input logic         b_mb1_empty,
  input logic         b_mb2_empty
);
  AST_MB1_CAPTURE: assert property (@(posedge clk_a) disable iff (!rst_n)
    accept_v[0] |=> (mail1_q == $past(a_din)) && !a_mb1_empty); // R2

  AST_MB2_CAPTURE: assert property (@(posedge clk_b) disable iff (!rst_n)
    accept_v[1] |=> (mail2_q == $past(b_din)) && !b_mb2_empty); // R3

  AST_MB1_REFUSED: assert property (@(posedge clk_a) disable iff (!rst_n)
    (wr_hit_v[0] && !a_mb1_empty) |=> $stable(mail1_q)); // R4

  AST_MB2_REFUSED: assert property (@(posedge clk_b) disable iff (!rst_n)
    (wr_hit_v[1] && !b_mb2_empty) |=> $stable(mail2_q)); // R4

  AST_MB1_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n)
    !wr_hit_v[0] |=> $stable(mail1_q)); // R5

  AST_MB2_QUIET: assert property (@(posedge clk_b) disable iff (!rst_n)
    !wr_hit_v[1] |=> $stable(mail2_q)); // R5

  AST_MB1_ACK_FLAG: assert property (@(posedge clk_b) disable iff (!rst_n)
    ack_v[0] |=> b_mb1_empty); // R7

  AST_MB2_ACK_FLAG: assert property (@(posedge clk_a) disable iff (!rst_n)
    ack_v[1] |=> a_mb2_empty); // R7
endmodule

bind dual_mailbox mbox_checker #(.W(W)) u_mbox_checker (
  .clk_a       (clk_a),
  .clk_b       (clk_b),
  .rst_n       (rst_n),
  .wr_hit_v    (wr_hit_v),
  .accept_v    (accept_v),
  .ack_v       (ack_v),
  .a_din       (a_din),
  .b_din       (b_din),
  .mail1_q     (mail1_q),
  .mail2_q     (mail2_q),
  .a_mb1_empty (a_mb1_empty),
  .a_mb2_empty (a_mb2_empty),
  .b_mb1_empty (b_mb1_empty),
  .b_mb2_empty (b_mb2_empty)
);

// File: tb/dual_mailbox_bench.sv
`timescale 1ns/1ps
module dual_mailbox_bench;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs = 0, a_dir = 0, a_en = 0, a_mbsel = 0;
  logic b_cs = 0, b_dir = 0, b_en = 0, b_mbsel = 0;
  logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe, a_mb1_empty, a_mb2_empty, b_mb1_empty, b_mb2_empty;

  dual_mailbox #(.W(W)) u_dual_mailbox (.*);

  // 125 MHz port A clock; port B at 12 ns, phased so no edges coincide
  always #4 clk_a = ~clk_a;
  initial begin
    #7;
    forever begin clk_b = 1'b1; #6; clk_b = 1'b0; #6; end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // channel 0 = mail1 (A writes, B reads), channel 1 = mail2
  logic [W-1:0] m_data [2];
  bit  w_pend [2];
  int  r_cnt  [2];   // reader-clock edges since write, -1 = none
  int  k_cnt  [2];   // writer-clock edges since read ack, -1 = none

  initial for (int i = 0; i < 2; i++) begin
    m_data[i] = '0; w_pend[i] = 0; r_cnt[i] = -1; k_cnt[i] = -1;
  end

  function automatic bit r_pend(int ch);
    return r_cnt[ch] == 2;
  endfunction

  // one edge of the clock of port p: port p writes channel p, reads channel 1-p
  task automatic model_edge(int p, bit cs, bit dir, bit en, bit mb, logic [W-1:0] din);
    int o = 1 - p;
    bit wr = cs && dir && en && mb;
    bit rd = cs && !dir && en && mb;
    if (wr && !w_pend[p]) begin
      m_data[p] = din; w_pend[p] = 1; r_cnt[p] = 0;
    end
    if (rd && r_pend(o)) begin
      r_cnt[o] = -1; k_cnt[o] = 0;
    end
    if (k_cnt[p] >= 0) begin
      k_cnt[p]++;
      if (k_cnt[p] == 2) begin w_pend[p] = 0; k_cnt[p] = -1; end
    end
    if (r_cnt[o] >= 0 && r_cnt[o] < 2) r_cnt[o]++;
  endtask

  always @(posedge clk_a) if (rst_n) model_edge(0, a_cs, a_dir, a_en, a_mbsel, a_din);
  always @(posedge clk_b) if (rst_n) model_edge(1, b_cs, b_dir, b_en, b_mbsel, b_din);

  // per-clock comparison, away from the active edge
  always @(negedge clk_a) if (rst_n && !done) begin
    chk("R2 R7 a_mb1_empty", a_mb1_empty, !w_pend[0]);
    chk("R6 R7 a_mb2_empty", a_mb2_empty, !r_pend(1));
    chk("R10 a_dout", a_dout, a_mbsel ? m_data[1] : a_fifo_q);
    chk("R11 a_oe", a_oe, a_cs && !a_dir);
  end
  always @(negedge clk_b) if (rst_n && !done) begin
    chk("R3 R7 b_mb2_empty", b_mb2_empty, !w_pend[1]);
    chk("R6 R7 b_mb1_empty", b_mb1_empty, !r_pend(0));
    chk("R10 b_dout", b_dout, b_mbsel ? m_data[0] : b_fifo_q);
    chk("R11 b_oe", b_oe, b_cs && !b_dir);
  end

  // ---------------- stimulus ----------------
  task automatic a_set(bit cs, bit dir, bit en, bit mb, logic [W-1:0] d);
    @(posedge clk_a); #2;
    a_cs = cs; a_dir = dir; a_en = en; a_mbsel = mb; a_din = d;
  endtask
  task automatic b_set(bit cs, bit dir, bit en, bit mb, logic [W-1:0] d);
    @(posedge clk_b); #3;
    b_cs = cs; b_dir = dir; b_en = en; b_mbsel = mb; b_din = d;
  endtask
  task automatic a_idle(); a_set(0, 0, 0, 0, '0); endtask
  task automatic b_idle(); b_set(0, 0, 0, 0, '0); endtask
  task automatic a_wait(int n); repeat (n) @(posedge clk_a); #2; endtask
  task automatic b_wait(int n); repeat (n) @(posedge clk_b); #3; endtask

  localparam logic [W-1:0] D1 = 36'h9_1234_5678;
  localparam logic [W-1:0] D2 = 36'h0_dead_beef;
  localparam logic [W-1:0] D3 = 36'hf_0f0f_0a0a;
  localparam logic [W-1:0] D4 = 36'h5_5555_aaaa;

  initial begin
    a_fifo_q = 36'h3_3333_3333;
    b_fifo_q = 36'hc_cccc_cccc;
    #30;
    // R1: flags and contents while reset is held
    chk("R1 a_mb1_empty in reset", a_mb1_empty, 1);
    chk("R1 a_mb2_empty in reset", a_mb2_empty, 1);
    chk("R1 b_mb1_empty in reset", b_mb1_empty, 1);
    chk("R1 b_mb2_empty in reset", b_mb2_empty, 1);
    #20 rst_n = 1'b1;

    // R1: both mailboxes read zero after reset
    a_set(1, 0, 0, 1, '0); #1 chk("R1 mail2 zero", a_dout, '0);
    b_set(1, 0, 0, 1, '0); #1 chk("R1 mail1 zero", b_dout, '0);
    a_idle(); b_idle();

    // R5: each qualifier dropped in turn leaves mail1 untouched
    a_set(0, 1, 1, 1, D3); a_set(1, 0, 1, 1, D3);
    a_set(1, 1, 0, 1, D3); a_set(1, 1, 1, 0, D3); a_idle();
    chk("R5 a_mb1_empty after non-writes", a_mb1_empty, 1);
    b_set(1, 0, 0, 1, '0); #1 chk("R5 mail1 unchanged", b_dout, '0);
    b_idle();

    // R2: write mail1
    a_set(1, 1, 1, 1, D1); a_idle();
    chk("R2 a_mb1_empty low after write", a_mb1_empty, 0);
    // R4: second write while pending is refused
    a_set(1, 1, 1, 1, D2); a_idle();
    // R6: reader flag low after two B edges
    b_wait(3);
    chk("R6 b_mb1_empty low", b_mb1_empty, 0);
    b_set(1, 0, 0, 1, '0); #1 chk("R4 mail1 kept first word", b_dout, D1);

    // R7: read acknowledges
    b_set(1, 0, 1, 1, '0); b_idle();
    chk("R7 b_mb1_empty high after read", b_mb1_empty, 1);
    a_wait(3);
    chk("R7 a_mb1_empty high after ack", a_mb1_empty, 1);
    // R8: data survives the read
    b_set(1, 0, 0, 1, '0); #1 chk("R8 mail1 after read", b_dout, D1);
    // R9: read while empty keeps data and flags
    b_set(1, 0, 1, 1, '0); b_idle();
    chk("R9 b_mb1_empty stays", b_mb1_empty, 1);
    a_wait(3);
    chk("R9 a_mb1_empty stays", a_mb1_empty, 1);
    b_set(1, 0, 1, 1, '0); #1 chk("R9 data on empty read", b_dout, D1);
    // R10, R11: select low routes the queue word; write direction not driving
    b_set(1, 0, 1, 0, '0); #1 chk("R10 b_dout fifo", b_dout, b_fifo_q);
    chk("R11 b_oe on read", b_oe, 1);
    b_set(1, 1, 0, 0, '0); #1 chk("R11 b_oe on write dir", b_oe, 0);
    b_idle();

    // R3: mail2 path, then read at A
    b_set(1, 1, 1, 1, D3); b_idle();
    chk("R3 b_mb2_empty low after write", b_mb2_empty, 0);
    a_wait(3);
    chk("R6 a_mb2_empty low", a_mb2_empty, 0);
    a_set(1, 0, 1, 1, '0); #1 chk("R3 a_dout mail2", a_dout, D3);
    a_idle();
    chk("R7 a_mb2_empty high after read", a_mb2_empty, 1);
    b_wait(3);
    chk("R7 b_mb2_empty high after ack", b_mb2_empty, 1);
    a_set(1, 0, 0, 0, '0); #1 chk("R10 a_dout fifo", a_dout, a_fifo_q);
    a_idle();

    // R2 R8: new write after acknowledge replaces mail1
    a_set(1, 1, 1, 1, D4); a_idle();
    b_wait(3);
    b_set(1, 0, 0, 1, '0); #1 chk("R8 mail1 replaced", b_dout, D4);
    b_idle();

    // back-to-back traffic in both directions, checked every clock
    for (int i = 0; i < 40; i++) begin
      fork
        a_set(1, i % 3 != 2, 1, 1, W'(i * 36'h1_0101));
        b_set(1, i % 2 == 0, 1, i % 5 != 4, W'(i * 36'h2_0303));
      join
    end
    a_idle(); b_idle();
    a_wait(6);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule